// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits behind the bus-write path of a parallel flash interface and turns a stream of write cycles (an address plus a data word) into single-clock command pulses for the program/erase controller. Most commands must be preceded by a two-write unlock prefix. Any write that does not fit the sequence so far sends the decoder back to read mode. The unlock addresses depend on the bus width, which a `byte_mode` input selects. Only the low address bits and data bits 7:0 take part in the comparison.

The decoder emits these pulses: reset, auto-select entry, program (carrying the full target address and data word), chip erase, block erase (carrying the block address), erase suspend and erase resume. It also reports a mode of read, auto-select or busy. The controller supplies two busy inputs. While a program or chip erase runs, every write is ignored. While a block erase runs, only the single-write reset and suspend commands are accepted.

The sequence machine has seven states. SQ_IDLE waits for the first cycle. SQ_UNL1 holds after AAh was written to the first unlock address. SQ_UNL2 holds after 55h was written to the second unlock address. SQ_PROG waits for the program address and data. SQ_ERS1, SQ_ERS2 and SQ_ERS3 track the second prefix of an erase. The transitions are:
- SQ_IDLE to SQ_UNL1 on AAh at the first unlock address.
- SQ_UNL1 to SQ_UNL2 on 55h at the second unlock address.
- SQ_UNL2 to SQ_PROG on A0h at the first unlock address.
- SQ_UNL2 to SQ_ERS1 on 80h at the first unlock address.
- SQ_ERS1 to SQ_ERS2 on AAh at the first unlock address.
- SQ_ERS2 to SQ_ERS3 on 55h at the second unlock address.
- Every other write returns to SQ_IDLE, either with a command pulse or as a break.
- While busy, the state is held at SQ_IDLE.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset all command pulses are low, `dec_mode` reads 2'b00 (read) and the sequence starts from its first cycle.
- R2: The first and second unlock addresses are 555h and 2AAh when `byte_mode` is 0, and AAAh and 555h when it is 1. Only address bits CMP_W-1:0 (default 12) and data bits 7:0 are compared. Word-mode unlock addresses do not unlock in byte mode.
- R3: The prefix followed by 90h at the first unlock address gives one `cmd_autosel` pulse. From that cycle `dec_mode` reads 2'b01 (auto-select) until another command pulse or a broken sequence.
- R4: The prefix followed by A0h at the first unlock address, then a fourth write, gives one `cmd_program` pulse. That pulse carries the fourth write's full address on `prog_addr` and its full data word on `prog_data`.
- R5: The prefix, 80h at the first unlock address, the prefix again, then 10h at the first unlock address, gives one `cmd_chip_erase` pulse.
- R6: The same five cycles followed by 30h at any address give one `cmd_block_erase` pulse, with that write's full address on `block_addr`.
- R7: A single F0h at any address in the first cycle, or F0h at any address after the prefix, gives one `cmd_reset` pulse and returns `dec_mode` to 2'b00.
- R8: A single B0h in the first cycle gives `cmd_suspend`. A single 30h in the first cycle gives `cmd_resume`.
- R9: A write that breaks a sequence gives no pulse, returns to read mode (`dec_mode` 2'b00) and discards the prefix seen so far.
- R10: While `ctl_busy` is 1 and `ctl_blk_ers` is 0, every write is ignored and `dec_mode` reads 2'b10 (busy).
- R11: While `ctl_busy` and `ctl_blk_ers` are both 1, only a single F0h (reset) or B0h (suspend) produces a pulse. Every other write, including an unlock prefix, is ignored.
- R12: A write is sampled only in a cycle with `wr_en` high. Its pulse appears in the following clock cycle and lasts exactly one cycle. At most one command pulse is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus-write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| byte_mode | input | 1 | 1 selects byte-mode unlock addresses |
| ctl_busy | input | 1 | Controller is running an operation |
| ctl_blk_ers | input | 1 | The running operation is a block erase |
| cmd_reset | output | 1 | Reset command pulse |
| cmd_autosel | output | 1 | Auto-select entry pulse |
| cmd_program | output | 1 | Program command pulse |
| prog_addr | output | ADDR_W | Program target address |
| prog_data | output | DATA_W | Program data |
| cmd_chip_erase | output | 1 | Chip erase pulse |
| cmd_block_erase | output | 1 | Block erase pulse |
| block_addr | output | ADDR_W | Address inside the block to erase |
| cmd_suspend | output | 1 | Erase suspend pulse |
| cmd_resume | output | 1 | Erase resume pulse |
| dec_mode | output | 2 | 00 read, 01 auto-select, 10 busy |

## Verification
The assertions assume that `ctl_busy` and `ctl_blk_ers` are clean levels from the controller. They also assume that `ctl_blk_ers` has meaning only while `ctl_busy` is high, and that `wr_data` is never X while `wr_en` is high. The stimulus respects this. Busy levels change only between writes, and never inside a cycle that carries a write. Every write is a single-cycle strobe followed by an idle cycle, so each pulse can be tied to exactly one write. The bench never lets the busy inputs depend on pulses the decoder emits, so mode and masking checks see stable busy levels.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_UNL1,
        SQ_UNL2,
        SQ_PROG,
        SQ_ERS1,
        SQ_ERS2,
        SQ_ERS3
    } seq_state_t;

    typedef enum logic [1:0] {
        MODE_READ    = 2'b00,
        MODE_AUTOSEL = 2'b01,
        MODE_BUSY    = 2'b10
    } dec_mode_t;

    typedef struct packed {
        logic rst;
        logic asel;
        logic prog;
        logic chip;
        logic blk;
        logic susp;
        logic resm;
    } cmd_evt_t;

    localparam logic [7:0] OP_UNLOCK_A = 8'hAA;
    localparam logic [7:0] OP_UNLOCK_B = 8'h55;
    localparam logic [7:0] OP_AUTOSEL  = 8'h90;
    localparam logic [7:0] OP_PROGRAM  = 8'hA0;
    localparam logic [7:0] OP_ERASE    = 8'h80;
    localparam logic [7:0] OP_CHIP     = 8'h10;
    localparam logic [7:0] OP_BLOCK    = 8'h30;
    localparam logic [7:0] OP_RESET    = 8'hF0;
    localparam logic [7:0] OP_SUSPEND  = 8'hB0;
    localparam logic [7:0] OP_RESUME   = 8'h30;

endpackage

// File: rtl/fcd_addr_match.sv
module fcd_addr_match #(
    parameter int unsigned CMP_W = 12
) (
    input  logic             byte_mode,
    input  logic [CMP_W-1:0] addr_low,
    output logic             hit_first,
    output logic             hit_second
);
    localparam logic [CMP_W-1:0] WORD_FIRST  = CMP_W'(12'h555);
    localparam logic [CMP_W-1:0] WORD_SECOND = CMP_W'(12'h2AA);
    localparam logic [CMP_W-1:0] BYTE_FIRST  = CMP_W'(12'hAAA);
    localparam logic [CMP_W-1:0] BYTE_SECOND = CMP_W'(12'h555);

    logic [CMP_W-1:0] first_a;
    logic [CMP_W-1:0] second_a;

    assign first_a    = byte_mode ? BYTE_FIRST  : WORD_FIRST;
    assign second_a   = byte_mode ? BYTE_SECOND : WORD_SECOND;
    assign hit_first  = (addr_low == first_a);
    assign hit_second = (addr_low == second_a);
endmodule

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm
    import fcd_pkg::*;
#(
    parameter int unsigned ADDR_W = 20,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              hit_first,
    input  logic              hit_second,
    input  logic              ctl_busy,
    input  logic              ctl_blk_ers,
    output cmd_evt_t          evt_nxt,
    output logic              brk_nxt,
    output cmd_evt_t          evt_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] data_q
);
    seq_state_t state_q;
    seq_state_t state_d;
    logic [7:0] op;

    assign op = wr_data[7:0];

    always_comb begin
        state_d = state_q;
        evt_nxt = '0;
        brk_nxt = 1'b0;
        if (ctl_busy) begin
            state_d = SQ_IDLE;
            if (wr_en && ctl_blk_ers) begin
                if (op == OP_RESET) begin
                    evt_nxt.rst = 1'b1;
                end else if (op == OP_SUSPEND) begin
                    evt_nxt.susp = 1'b1;
                end
            end
        end else if (wr_en) begin
            state_d = SQ_IDLE;
            unique case (state_q)
                SQ_IDLE: begin
                    if (op == OP_RESET) begin
                        evt_nxt.rst = 1'b1;
                    end else if (op == OP_SUSPEND) begin
                        evt_nxt.susp = 1'b1;
                    end else if (op == OP_RESUME) begin
                        evt_nxt.resm = 1'b1;
                    end else if (op == OP_UNLOCK_A && hit_first) begin
                        state_d = SQ_UNL1;
                    end else begin
                        brk_nxt = 1'b1;
                    end
                end
                SQ_UNL1: begin
                    if (op == OP_UNLOCK_B && hit_second) begin
                        state_d = SQ_UNL2;
                    end else begin
                        brk_nxt = 1'b1;
                    end
                end
                SQ_UNL2: begin
                    if (op == OP_RESET) begin
                        evt_nxt.rst = 1'b1;
                    end else if (hit_first && op == OP_AUTOSEL) begin
                        evt_nxt.asel = 1'b1;
                    end else if (hit_first && op == OP_PROGRAM) begin
                        state_d = SQ_PROG;
                    end else if (hit_first && op == OP_ERASE) begin
                        state_d = SQ_ERS1;
                    end else begin
                        brk_nxt = 1'b1;
                    end
                end
                SQ_PROG: begin
                    evt_nxt.prog = 1'b1;
                end
                SQ_ERS1: begin
                    if (op == OP_UNLOCK_A && hit_first) begin
                        state_d = SQ_ERS2;
                    end else begin
                        brk_nxt = 1'b1;
                    end
                end
                SQ_ERS2: begin
                    if (op == OP_UNLOCK_B && hit_second) begin
                        state_d = SQ_ERS3;
                    end else begin
                        brk_nxt = 1'b1;
                    end
                end
                SQ_ERS3: begin
                    if (op == OP_CHIP && hit_first) begin
                        evt_nxt.chip = 1'b1;
                    end else if (op == OP_BLOCK) begin
                        evt_nxt.blk = 1'b1;
                    end else begin
                        brk_nxt = 1'b1;
                    end
                end
                default: begin
                    brk_nxt = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_q  <= '0;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            evt_q <= evt_nxt;
            if (evt_nxt.prog || evt_nxt.blk) begin
                addr_q <= wr_addr;
            end
            if (evt_nxt.prog) begin
                data_q <= wr_data;
            end
        end
    end
endmodule

// File: rtl/fcd_mode_track.sv
module fcd_mode_track
    import fcd_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  cmd_evt_t  evt_nxt,
    input  logic      brk_nxt,
    input  logic      ctl_busy,
    output dec_mode_t mode
);
    logic asel_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            asel_q <= 1'b0;
        end else if (evt_nxt.asel) begin
            asel_q <= 1'b1;
        end else if (brk_nxt || (|evt_nxt)) begin
            asel_q <= 1'b0;
        end
    end

    always_comb begin
        if (ctl_busy) begin
            mode = MODE_BUSY;
        end else if (asel_q) begin
            mode = MODE_AUTOSEL;
        end else begin
            mode = MODE_READ;
        end
    end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import fcd_pkg::*;
#(
    parameter int unsigned ADDR_W = 20,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned CMP_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              byte_mode,
    input  logic              ctl_busy,
    input  logic              ctl_blk_ers,
    output logic              cmd_reset,
    output logic              cmd_autosel,
    output logic              cmd_program,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [DATA_W-1:0] prog_data,
    output logic              cmd_chip_erase,
    output logic              cmd_block_erase,
    output logic [ADDR_W-1:0] block_addr,
    output logic              cmd_suspend,
    output logic              cmd_resume,
    output logic [1:0]        dec_mode
);
    logic              hit_first;
    logic              hit_second;
    cmd_evt_t          evt_nxt;
    cmd_evt_t          evt_q;
    logic              brk_nxt;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    dec_mode_t         mode;

    fcd_addr_match #(.CMP_W(CMP_W)) match_i (
        .byte_mode  (byte_mode),
        .addr_low   (wr_addr[CMP_W-1:0]),
        .hit_first  (hit_first),
        .hit_second (hit_second)
    );

    fcd_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .hit_first   (hit_first),
        .hit_second  (hit_second),
        .ctl_busy    (ctl_busy),
        .ctl_blk_ers (ctl_blk_ers),
        .evt_nxt     (evt_nxt),
        .brk_nxt     (brk_nxt),
        .evt_q       (evt_q),
        .addr_q      (addr_q),
        .data_q      (data_q)
    );

    fcd_mode_track mode_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_nxt  (evt_nxt),
        .brk_nxt  (brk_nxt),
        .ctl_busy (ctl_busy),
        .mode     (mode)
    );

    assign cmd_reset       = evt_q.rst;
    assign cmd_autosel     = evt_q.asel;
    assign cmd_program     = evt_q.prog;
    assign cmd_chip_erase  = evt_q.chip;
    assign cmd_block_erase = evt_q.blk;
    assign cmd_suspend     = evt_q.susp;
    assign cmd_resume      = evt_q.resm;
    assign prog_addr       = addr_q;
    assign prog_data       = data_q;
    assign block_addr      = addr_q;
    assign dec_mode        = mode;
endmodule

// File: rtl/fcd_checker.sv
module fcd_checker #(
    parameter int unsigned DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic              ctl_busy,
    input logic              ctl_blk_ers,
    input logic              cmd_reset,
    input logic              cmd_autosel,
    input logic              cmd_program,
    input logic              cmd_chip_erase,
    input logic              cmd_block_erase,
    input logic              cmd_suspend,
    input logic              cmd_resume,
    input logic [1:0]        dec_mode
);
    logic [6:0] pulses;
    assign pulses = {cmd_reset, cmd_autosel, cmd_program, cmd_chip_erase,
                     cmd_block_erase, cmd_suspend, cmd_resume};

    a_r12_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pulses));

    a_r12_no_write_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (pulses == 7'd0));

    a_r4_program_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_program |=> !cmd_program);

    a_r10_busy_masks_all: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_busy && !ctl_blk_ers) |=> (pulses == 7'd0));

    a_r10_busy_mode: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_busy |-> (dec_mode == 2'b10));

    a_r11_blk_busy_limited: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_busy && ctl_blk_ers) |=>
            !(cmd_autosel || cmd_program || cmd_chip_erase || cmd_block_erase || cmd_resume));

    a_r11_blk_busy_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_busy && ctl_blk_ers && wr_en && wr_data[7:0] == 8'hF0) |=> cmd_reset);

    a_r3_autosel_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_autosel && !ctl_busy) |-> (dec_mode == 2'b01));
endmodule

bind flash_cmd_decoder fcd_checker #(.DATA_W(DATA_W)) chk_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .wr_en           (wr_en),
    .wr_data         (wr_data),
    .ctl_busy        (ctl_busy),
    .ctl_blk_ers     (ctl_blk_ers),
    .cmd_reset       (cmd_reset),
    .cmd_autosel     (cmd_autosel),
    .cmd_program     (cmd_program),
    .cmd_chip_erase  (cmd_chip_erase),
    .cmd_block_erase (cmd_block_erase),
    .cmd_suspend     (cmd_suspend),
    .cmd_resume      (cmd_resume),
    .dec_mode        (dec_mode)
);

// File: tb/flash_cmd_decoder_tb_top.sv
module flash_cmd_decoder_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 20;
    localparam int DW = 16;

    localparam int K_NONE = 0;
    localparam int K_RST  = 1;
    localparam int K_ASEL = 2;
    localparam int K_PROG = 3;
    localparam int K_CHIP = 4;
    localparam int K_BLK  = 5;
    localparam int K_SUSP = 6;
    localparam int K_RESM = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          byte_mode = 1'b0;
    logic          ctl_busy = 1'b0;
    logic          ctl_blk_ers = 1'b0;
    logic          cmd_reset, cmd_autosel, cmd_program, cmd_chip_erase;
    logic          cmd_block_erase, cmd_suspend, cmd_resume;
    logic [AW-1:0] prog_addr, block_addr;
    logic [DW-1:0] prog_data;
    logic [1:0]    dec_mode;

    int n_checks = 0;
    int n_fail = 0;
    logic wr_seen = 1'b0;

    int            q_kind[$];
    logic [AW-1:0] q_addr[$];
    logic [DW-1:0] q_data[$];
    logic [1:0]    q_mode[$];
    string         q_tag[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_cmd_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .byte_mode(byte_mode), .ctl_busy(ctl_busy), .ctl_blk_ers(ctl_blk_ers),
        .cmd_reset(cmd_reset), .cmd_autosel(cmd_autosel), .cmd_program(cmd_program),
        .prog_addr(prog_addr), .prog_data(prog_data), .cmd_chip_erase(cmd_chip_erase),
        .cmd_block_erase(cmd_block_erase), .block_addr(block_addr),
        .cmd_suspend(cmd_suspend), .cmd_resume(cmd_resume), .dec_mode(dec_mode)
    );

    function automatic int seen_kind();
        int n;
        int k;
        n = 0;
        k = K_NONE;
        if (cmd_reset)       begin n++; k = K_RST;  end
        if (cmd_autosel)     begin n++; k = K_ASEL; end
        if (cmd_program)     begin n++; k = K_PROG; end
        if (cmd_chip_erase)  begin n++; k = K_CHIP; end
        if (cmd_block_erase) begin n++; k = K_BLK;  end
        if (cmd_suspend)     begin n++; k = K_SUSP; end
        if (cmd_resume)      begin n++; k = K_RESM; end
        return (n > 1) ? 99 : k;
    endfunction

    // driver: one write cycle followed by one idle cycle
    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input int kind,
                      input logic [1:0] mode, input string tag);
        @(negedge clk);
        q_kind.push_back(kind);
        q_addr.push_back(a);
        q_data.push_back(d);
        q_mode.push_back(mode);
        q_tag.push_back(tag);
        wr_addr = a;
        wr_data = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    always @(posedge clk) wr_seen <= wr_en;

    // monitor: compares each write's result one cycle later
    always @(negedge clk) begin
        if (rst_n) begin
            int k;
            k = seen_kind();
            if (wr_seen && q_kind.size() > 0) begin
                int ek;
                logic [AW-1:0] ea;
                logic [DW-1:0] ed;
                logic [1:0] em;
                string t;
                logic [AW-1:0] oa;
                ek = q_kind.pop_front();
                ea = q_addr.pop_front();
                ed = q_data.pop_front();
                em = q_mode.pop_front();
                t  = q_tag.pop_front();
                oa = (k == K_BLK) ? block_addr : prog_addr;
                n_checks++;
                if (k != ek || dec_mode != em
                    || (ek == K_PROG && (prog_addr != ea || prog_data != ed))
                    || (ek == K_BLK && block_addr != ea)) begin
                    n_fail++;
                    $display("FAIL %s: kind %0d mode %0d addr %h data %h, expected kind %0d mode %0d addr %h data %h",
                             t, k, dec_mode, oa, prog_data, ek, em, ea, ed);
                end
            end else if (!wr_seen) begin
                n_checks++;
                if (k != K_NONE) begin
                    n_fail++;
                    $display("FAIL R12: pulse kind %0d without a write, expected kind 0", k);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        n_checks++;
        if (seen_kind() != K_NONE || dec_mode != 2'b00) begin
            n_fail++;
            $display("FAIL R1: kind %0d mode %0d, expected kind 0 mode 0", seen_kind(), dec_mode);
        end
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // word mode, upper address and data bits junk
        byte_mode = 1'b0;
        wr(20'hF1555, 16'h12AA, K_NONE, 2'b00, "R2");
        wr(20'h3A2AA, 16'hFF55, K_NONE, 2'b00, "R2");
        wr(20'h00555, 16'hAB90, K_ASEL, 2'b01, "R3");
        wr(20'h12345, 16'h00F0, K_RST,  2'b00, "R7");

        // R4 program
        wr(20'h00555, 16'h00AA, K_NONE, 2'b00, "R4");
        wr(20'h002AA, 16'h0055, K_NONE, 2'b00, "R4");
        wr(20'h00555, 16'h00A0, K_NONE, 2'b00, "R4");
        wr(20'h4ABCD, 16'hBEEF, K_PROG, 2'b00, "R4");

        // R5 chip erase
        wr(20'h00555, 16'h00AA, K_NONE, 2'b00, "R5");
        wr(20'h002AA, 16'h0055, K_NONE, 2'b00, "R5");
        wr(20'h00555, 16'h0080, K_NONE, 2'b00, "R5");
        wr(20'h00555, 16'h00AA, K_NONE, 2'b00, "R5");
        wr(20'h002AA, 16'h0055, K_NONE, 2'b00, "R5");
        wr(20'h00555, 16'h0010, K_CHIP, 2'b00, "R5");

        // byte mode, R6 block erase
        byte_mode = 1'b1;
        wr(20'h00AAA, 16'h00AA, K_NONE, 2'b00, "R6");
        wr(20'h00555, 16'h0055, K_NONE, 2'b00, "R6");
        wr(20'h00AAA, 16'h0080, K_NONE, 2'b00, "R6");
        wr(20'h00AAA, 16'h00AA, K_NONE, 2'b00, "R6");
        wr(20'h00555, 16'h0055, K_NONE, 2'b00, "R6");
        wr(20'h2C01E, 16'h0030, K_BLK,  2'b00, "R6");

        // R2: word addresses do not unlock in byte mode
        wr(20'h00555, 16'h00AA, K_NONE, 2'b00, "R2");
        wr(20'h002AA, 16'h0055, K_NONE, 2'b00, "R2");
        wr(20'h00555, 16'h0090, K_NONE, 2'b00, "R2");

        // byte auto-select, then prefixed reset (R7)
        wr(20'h00AAA, 16'h00AA, K_NONE, 2'b00, "R3");
        wr(20'h00555, 16'h0055, K_NONE, 2'b00, "R3");
        wr(20'h00AAA, 16'h0090, K_ASEL, 2'b01, "R3");
        wr(20'h00AAA, 16'h00AA, K_NONE, 2'b01, "R7");
        wr(20'h00555, 16'h0055, K_NONE, 2'b01, "R7");
        wr(20'h7F000, 16'h00F0, K_RST,  2'b00, "R7");

        // R9: broken sequences
        byte_mode = 1'b0;
        wr(20'h00555, 16'h00AA, K_NONE, 2'b00, "R9");
        wr(20'h002AA, 16'h0056, K_NONE, 2'b00, "R9");
        wr(20'h00555, 16'h0090, K_NONE, 2'b00, "R9");
        wr(20'h00555, 16'h00AA, K_NONE, 2'b00, "R9");
        wr(20'h002AA, 16'h0055, K_NONE, 2'b00, "R9");
        wr(20'h00555, 16'h0090, K_ASEL, 2'b01, "R9");
        wr(20'h00123, 16'h0077, K_NONE, 2'b00, "R9");

        // R8 suspend and resume
        wr(20'h54321, 16'h00B0, K_SUSP, 2'b00, "R8");
        wr(20'h00001, 16'h0030, K_RESM, 2'b00, "R8");

        // R10 busy with program or chip erase
        @(negedge clk);
        ctl_busy = 1'b1;
        ctl_blk_ers = 1'b0;
        wr(20'h00000, 16'h00F0, K_NONE, 2'b10, "R10");
        wr(20'h00000, 16'h00B0, K_NONE, 2'b10, "R10");
        wr(20'h00555, 16'h00AA, K_NONE, 2'b10, "R10");
        wr(20'h002AA, 16'h0055, K_NONE, 2'b10, "R10");
        wr(20'h00555, 16'h0090, K_NONE, 2'b10, "R10");

        // R11 busy with block erase
        @(negedge clk);
        ctl_blk_ers = 1'b1;
        wr(20'h00000, 16'h0030, K_NONE, 2'b10, "R11");
        wr(20'h00000, 16'h00B0, K_SUSP, 2'b10, "R11");
        wr(20'h00000, 16'h00F0, K_RST,  2'b10, "R11");
        wr(20'h00555, 16'h00AA, K_NONE, 2'b10, "R11");
        wr(20'h002AA, 16'h0055, K_NONE, 2'b10, "R11");
        wr(20'h00555, 16'h00A0, K_NONE, 2'b10, "R11");

        // back to idle: decoder must start afresh
        @(negedge clk);
        ctl_busy = 1'b0;
        ctl_blk_ers = 1'b0;
        wr(20'h00555, 16'h00AA, K_NONE, 2'b00, "R4");
        wr(20'h002AA, 16'h0055, K_NONE, 2'b00, "R4");
        wr(20'h00555, 16'h00A0, K_NONE, 2'b00, "R4");
        wr(20'h00010, 16'h1234, K_PROG, 2'b00, "R4");

        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule